// File: doc/BRIEF.md
# Multi-Window Memory Address Decoder

This block sits on the system bus and decides whether a memory cycle falls inside one of several programmable memory windows. Each window has a start page, an end page and an enable bit. On every memory cycle the 24-bit system address is compared with all enabled windows. The block reports a hit flag and the number of the window that matched. The match logic is purely combinational, so the result is valid in the same cycle as the address.

Software programs the windows through an 8-bit indexed register port. A write to the index port selects a register. A following write to the data port loads that register. Reads return the selected register at any time. Address matching works on 4 KB pages, which are bits 23:12 of the address. The first 64 KB of the address space can never be claimed by any window. If software programs overlapping windows by mistake, the lowest-numbered window is reported.

Top module: `mem_window_decoder`

## Requirements
- R1: After reset every register reads 00h, the index is 00h, and no address produces a hit.
- R2: Window w owns four registers, starting at index 10h + 8*w:
  - base+0: start page bits 7:0 (address bits 19:12).
  - base+1: start page bits 11:8 (address bits 23:20) in data bits 3:0.
  - base+2: end page bits 7:0.
  - base+3: end page bits 11:8 in data bits 3:0.
  - Unused upper bits of the two high registers read as 0.
- R3: The enable register sits at index 06h. Data bit w enables window w, for w = 0 to 4. Bits 7:5 read as 0.
- R4: A window matches only when all of these hold:
  - the bus memory-cycle input is high;
  - its enable bit is set;
  - start page <= address bits 23:12 <= end page, with both bounds inclusive.
- R5: Address bits 11:0 have no effect on matching.
- R6: No window matches an address whose bits 23:16 are all zero, whatever the programming.
- R7: A window whose end page is below its start page never matches.
- R8: When several windows match, the hit number is the lowest-numbered matching window.
- R9: A data-port write changes the register on the next rising clock edge. The match outputs follow the new value from that edge on, with no further delay.
- R10: Index values outside the enable register and the four registers of each window read as 00h. A data write to such an index changes no register.
- R11: When there is no hit, the window-number output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released synchronously. |
| idx_wr | input | 1 | Loads wdata into the index register |
| data_wr | input | 1 | Writes wdata into the register selected by the index |
| wdata | input | 8 | Write data for the index and data ports |
| rdata | output | 8 | Contents of the currently indexed register |
| bus_addr | input | 24 | System memory address |
| bus_mem_cycle | input | 1 | High during a bus memory cycle |
| hit | output | 1 | The address falls in an enabled window |
| hit_win | output | 3 | Number of the matching window; 0 when there is no hit |

## Verification
The assertions check the following on every cycle:
- no hit ever occurs below 64 KB;
- a quiet cycle gives no hit;
- the reported window really matches;
- no lower-numbered window also matches;
- a matching window has ordered bounds;
- the window-number output is zero when there is no hit;
- enable writes land one edge later.

Only the bench's scenarios can show the rest. That covers:
- full page-by-page sweeps against an arithmetic model under several programmings;
- the inclusive bound edges;
- independence from the low twelve address bits;
- the register layout on readback;
- unmapped indexes leaving the registers untouched;
- the cycle in which a write becomes visible.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int NUM_WIN   = 5;
  localparam int ADDR_W    = 24;
  localparam int GRAIN_W   = 12;
  localparam int PAGE_W    = ADDR_W - GRAIN_W;
  localparam int HI_W      = PAGE_W - 8;
  localparam int WIN_IDX_W = $clog2(NUM_WIN);

  typedef logic [PAGE_W-1:0]    page_t;
  typedef logic [WIN_IDX_W-1:0] win_idx_t;

  typedef struct packed {
    page_t first;
    page_t last;
  } win_cfg_t;
endpackage

// File: rtl/mwd_regfile.sv
module mwd_regfile
  import mwd_pkg::*;
#(
  parameter int BASE_IDX = 8'h10,
  parameter int STRIDE   = 8,
  parameter int EN_IDX   = 8'h06
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          idx_wr,
  input  logic                          data_wr,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    rdata,
  output win_cfg_t [NUM_WIN-1:0]        cfg_o,
  output logic [NUM_WIN-1:0]            en_o
);
  localparam int SPAN  = NUM_WIN * STRIDE;
  localparam int SUB_W = $clog2(STRIDE);
  typedef logic [SUB_W-1:0] sub_t;

  logic [7:0]             idx_q, idx_d;
  win_cfg_t [NUM_WIN-1:0] cfg_q, cfg_d;
  logic [NUM_WIN-1:0]     en_q, en_d;

  logic [7:0] off;
  logic       in_range;
  logic       sub_ok;
  win_idx_t   sel_win;
  sub_t       sel_sub;

  // decode the index into window number and register slot
  always_comb begin
    off      = idx_q - 8'(BASE_IDX);
    in_range = (int'(idx_q) >= BASE_IDX) && (int'(idx_q) < BASE_IDX + SPAN);
    sel_win  = win_idx_t'(int'(off) / STRIDE);
    sel_sub  = sub_t'(int'(off) % STRIDE);
    sub_ok   = in_range && (int'(sel_sub) < 4);
  end

  // next state
  always_comb begin
    idx_d = idx_q;
    cfg_d = cfg_q;
    en_d  = en_q;
    if (idx_wr) begin
      idx_d = wdata;
    end
    if (data_wr) begin
      if (int'(idx_q) == EN_IDX) begin
        en_d = wdata[NUM_WIN-1:0];
      end
      for (int w = 0; w < NUM_WIN; w++) begin
        if (sub_ok && (int'(sel_win) == w)) begin
          case (sel_sub)
            sub_t'(0): cfg_d[w].first[7:0]        = wdata;
            sub_t'(1): cfg_d[w].first[PAGE_W-1:8] = wdata[HI_W-1:0];
            sub_t'(2): cfg_d[w].last[7:0]         = wdata;
            sub_t'(3): cfg_d[w].last[PAGE_W-1:8]  = wdata[HI_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cfg_q <= '0;
      en_q  <= '0;
    end else begin
      idx_q <= idx_d;
      cfg_q <= cfg_d;
      en_q  <= en_d;
    end
  end

  // readback
  always_comb begin
    rdata = '0;
    if (int'(idx_q) == EN_IDX) begin
      rdata[NUM_WIN-1:0] = en_q;
    end
    for (int w = 0; w < NUM_WIN; w++) begin
      if (sub_ok && (int'(sel_win) == w)) begin
        case (sel_sub)
          sub_t'(0): rdata           = cfg_q[w].first[7:0];
          sub_t'(1): rdata[HI_W-1:0] = cfg_q[w].first[PAGE_W-1:8];
          sub_t'(2): rdata           = cfg_q[w].last[7:0];
          sub_t'(3): rdata[HI_W-1:0] = cfg_q[w].last[PAGE_W-1:8];
          default: ;
        endcase
      end
    end
  end

  assign cfg_o = cfg_q;
  assign en_o  = en_q;

  AST_EN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && int'(idx_q) == EN_IDX) |=> (en_q == $past(wdata[NUM_WIN-1:0]))); // R3
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> ($stable(cfg_q) && $stable(en_q))); // R9
endmodule

// File: rtl/mwd_window_cmp.sv
module mwd_window_cmp
  import mwd_pkg::*;
#(
  parameter int FLOOR_BITS = 4
) (
  input  page_t    page_i,
  input  win_cfg_t cfg_i,
  input  logic     en_i,
  output logic     match_o
);
  logic above_floor;
  logic ge_first;
  logic le_last;

  always_comb begin
    above_floor = |page_i[PAGE_W-1:FLOOR_BITS];
    ge_first    = (page_i >= cfg_i.first);
    le_last     = (page_i <= cfg_i.last);
    match_o     = en_i && above_floor && ge_first && le_last;
  end
endmodule

// File: rtl/mwd_prio.sv
module mwd_prio
  import mwd_pkg::*;
(
  input  logic [NUM_WIN-1:0] req_i,
  input  logic               valid_i,
  output logic               hit_o,
  output win_idx_t           win_o
);
  always_comb begin
    hit_o = 1'b0;
    win_o = '0;
    if (valid_i) begin
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
        if (req_i[w]) begin
          hit_o = 1'b1;
          win_o = win_idx_t'(w);
        end
      end
    end
  end
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import mwd_pkg::*;
#(
  parameter int BASE_IDX   = 8'h10,
  parameter int STRIDE     = 8,
  parameter int EN_IDX     = 8'h06,
  parameter int FLOOR_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_wr,
  input  logic                 data_wr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_mem_cycle,
  output logic                 hit,
  output logic [WIN_IDX_W-1:0] hit_win
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  win_cfg_t [NUM_WIN-1:0] cfg;
  logic [NUM_WIN-1:0]     en;
  logic [NUM_WIN-1:0]     match;
  page_t                  page;

  assign page = bus_addr[ADDR_W-1:GRAIN_W];

  mwd_regfile #(
    .BASE_IDX (BASE_IDX),
    .STRIDE   (STRIDE),
    .EN_IDX   (EN_IDX)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .idx_wr  (idx_wr),
    .data_wr (data_wr),
    .wdata   (wdata),
    .rdata   (rdata),
    .cfg_o   (cfg),
    .en_o    (en)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    mwd_window_cmp #(.FLOOR_BITS(FLOOR_BITS)) u_cmp (
      .page_i  (page),
      .cfg_i   (cfg[w]),
      .en_i    (en[w]),
      .match_o (match[w])
    );

    AST_BOUNDS_ORDERED: assert property (@(posedge clk) disable iff (!rst_int_n)
      match[w] |-> (cfg[w].first <= cfg[w].last)); // R7
  end

  mwd_prio u_prio (
    .req_i   (match),
    .valid_i (bus_mem_cycle),
    .hit_o   (hit),
    .win_o   (hit_win)
  );

  logic [NUM_WIN-1:0] lower_mask;
  assign lower_mask = NUM_WIN'((1 << hit_win) - 1);

  AST_NO_FLOOR_HIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr[ADDR_W-1:GRAIN_W+FLOOR_BITS] == '0) |-> !hit); // R6
  AST_QUIET_CYCLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_mem_cycle |-> !hit); // R4
  AST_WIN_MATCHES: assert property (@(posedge clk) disable iff (!rst_int_n)
    hit |-> (match[hit_win] && en[hit_win])); // R4
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_int_n)
    hit |-> ((match & lower_mask) == '0)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    !hit |-> (hit_win == '0)); // R11
endmodule

// File: tb/mem_window_decoder_bench.sv
module mem_window_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        idx_wr, data_wr;
  logic [7:0]  wdata, rdata;
  logic [23:0] bus_addr;
  logic        bus_mem_cycle;
  logic        hit;
  logic [2:0]  hit_win;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic [11:0] m_first [5];
  logic [11:0] m_last  [5];
  logic [4:0]  m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_window_decoder u_mem_window_decoder (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
    .wdata(wdata), .rdata(rdata), .bus_addr(bus_addr),
    .bus_mem_cycle(bus_mem_cycle), .hit(hit), .hit_win(hit_win)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk); idx_wr = 1'b1; wdata = idx;
    @(negedge clk); idx_wr = 1'b0; data_wr = 1'b1; wdata = val;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [7:0] val);
    @(negedge clk); idx_wr = 1'b1; wdata = idx;
    @(negedge clk); idx_wr = 1'b0;
    #1 val = rdata;
  endtask

  task automatic prog_win(input int w, input logic [11:0] f, input logic [11:0] l);
    wr_reg(8'(8'h10 + 8*w),     f[7:0]);
    wr_reg(8'(8'h10 + 8*w + 1), {4'h0, f[11:8]});
    wr_reg(8'(8'h10 + 8*w + 2), l[7:0]);
    wr_reg(8'(8'h10 + 8*w + 3), {4'h0, l[11:8]});
    m_first[w] = f;
    m_last[w]  = l;
  endtask

  task automatic set_en(input logic [4:0] e);
    wr_reg(8'h06, {3'b000, e});
    m_en = e;
  endtask

  task automatic probe(input logic [23:0] a, input logic cyc);
    @(negedge clk); bus_addr = a; bus_mem_cycle = cyc;
    #1;
  endtask

  function automatic void model(input logic [11:0] p, input logic cyc,
                                output logic h, output logic [2:0] wn, output int cnt);
    h = 1'b0; wn = 3'd0; cnt = 0;
    if (cyc && p >= 12'h010) begin
      for (int w = 4; w >= 0; w--) begin
        if (m_en[w] && p >= m_first[w] && p <= m_last[w]) begin
          h = 1'b1; wn = 3'(w); cnt++;
        end
      end
    end
  endfunction

  task automatic sweep(input logic cyc);
    for (int p = 0; p < 4096; p++) begin
      logic       eh;
      logic [2:0] ew;
      int         cnt;
      string      tag;
      logic [11:0] lo;
      lo = 12'((p * 37 + 5) % 4096);
      probe({12'(p), lo}, cyc);
      model(12'(p), cyc, eh, ew, cnt);
      if (p < 16)        tag = "R6 floor";
      else if (cnt > 1)  tag = "R8 overlap";
      else if (!cyc)     tag = "R4 no cycle";
      else               tag = "R4 sweep";
      check(tag, {28'h0, hit, hit_win}, {28'h0, eh, ew});
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (!finished && $time > CLK_PERIOD * WD_LIMIT) begin
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; idx_wr = 1'b0; data_wr = 1'b0; wdata = '0;
    bus_addr = '0; bus_mem_cycle = 1'b0; m_en = '0;
    for (int w = 0; w < 5; w++) begin m_first[w] = '0; m_last[w] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    #1 check("R1 index reset readback", {24'h0, rdata}, 32'h0);
    for (int i = 0; i < 64; i++) begin
      rd_reg(8'(i), v);
      check("R1 register reset", {24'h0, v}, 32'h0);
    end
    probe(24'h123456, 1'b1);
    check("R1 no hit after reset", {28'h0, hit, hit_win}, 32'h0);

    // R2: register layout and readback
    prog_win(0, 12'h010, 12'h01F);
    prog_win(1, 12'h000, 12'h00F);
    prog_win(2, 12'h800, 12'h8FF);
    prog_win(3, 12'h100, 12'h1FF);
    prog_win(4, 12'hFF0, 12'hFFF);
    wr_reg(8'h29, 8'hF1);
    rd_reg(8'h29, v);
    check("R2 start high upper bits zero", {24'h0, v}, 32'h01);
    rd_reg(8'h22, v);
    check("R2 end low of window 2", {24'h0, v}, 32'hFF);
    rd_reg(8'h23, v);
    check("R2 end high of window 2", {24'h0, v}, 32'h08);
    rd_reg(8'h30, v);
    check("R2 start low of window 4", {24'h0, v}, 32'hF0);

    // R3: enable register
    wr_reg(8'h06, 8'hFF);
    rd_reg(8'h06, v);
    check("R3 enable readback upper bits zero", {24'h0, v}, 32'h1F);

    // R10: unmapped indexes
    wr_reg(8'h14, 8'hAA);
    wr_reg(8'h0F, 8'h55);
    wr_reg(8'h3C, 8'h77);
    rd_reg(8'h14, v);
    check("R10 unmapped reads zero", {24'h0, v}, 32'h0);
    rd_reg(8'h3C, v);
    check("R10 unmapped past last window", {24'h0, v}, 32'h0);
    rd_reg(8'h10, v);
    check("R10 neighbour untouched", {24'h0, v}, 32'h10);
    rd_reg(8'h18, v);
    check("R10 window 1 untouched", {24'h0, v}, 32'h00);

    // R4/R6/R5 sweep with window 3 disabled, window 1 below floor
    set_en(5'b10111);
    sweep(1'b1);

    // R5: low bits ignored at inclusive edges
    probe(24'h010000, 1'b1);
    check("R5 first byte of window 0", {28'h0, hit, hit_win}, {28'h0, 1'b1, 3'd0});
    probe(24'h01FFFF, 1'b1);
    check("R5 last byte of window 0", {28'h0, hit, hit_win}, {28'h0, 1'b1, 3'd0});
    probe(24'h020000, 1'b1);
    check("R4 one page past end", {28'h0, hit, hit_win}, 32'h0);
    probe(24'h8FFFFF, 1'b1);
    check("R5 last byte of window 2", {28'h0, hit, hit_win}, {28'h0, 1'b1, 3'd2});
    probe(24'h00FFFF, 1'b1);
    check("R6 top of floor", {28'h0, hit, hit_win}, 32'h0);

    // R4: bus cycle gate
    sweep(1'b0);

    // R9: write becomes visible on the edge after the data write
    probe(24'h150000, 1'b1);
    check("R9 window 3 still disabled", {28'h0, hit, hit_win}, 32'h0);
    @(negedge clk); idx_wr = 1'b1; wdata = 8'h06;
    @(negedge clk); idx_wr = 1'b0; data_wr = 1'b1; wdata = 8'h1F;
    #1 check("R9 before edge", {28'h0, hit, hit_win}, 32'h0);
    @(negedge clk); data_wr = 1'b0;
    #1 check("R9 after edge", {28'h0, hit, hit_win}, {28'h0, 1'b1, 3'd3});
    m_en = 5'h1F;

    // R7 and R8: inverted bounds and overlap
    prog_win(3, 12'h100, 12'h3FF);
    prog_win(1, 12'h200, 12'h2FF);
    prog_win(2, 12'h500, 12'h4FF);
    sweep(1'b1);
    probe(24'h4FF000, 1'b1);
    check("R7 inverted window at end page", {28'h0, hit, hit_win}, 32'h0);
    probe(24'h500FFF, 1'b1);
    check("R7 inverted window at start page", {28'h0, hit, hit_win}, 32'h0);
    probe(24'h250123, 1'b1);
    check("R8 lower window wins", {28'h0, hit, hit_win}, {28'h0, 1'b1, 3'd1});
    probe(24'h300000, 1'b1);
    check("R8 upper window alone", {28'h0, hit, hit_win}, {28'h0, 1'b1, 3'd3});

    // R11: window number zero on miss
    probe(24'hA00000, 1'b1);
    check("R11 miss gives zero number", {28'h0, hit, hit_win}, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule